// File: doc/BRIEF.md
# ECC Error Address Logger

This block sits beside a memory controller's ECC checker. It records where the first correctable or uncorrectable memory error happened. When the checker reports an error, the logger keeps the 4 KB page number of the failing address. It also raises a status flag that tells software whether the error was single-bit or multi-bit.

After the first capture the log is frozen, so later errors cannot overwrite the evidence. Software reads the 32-bit log word, handles the error, and then writes ones to the status flags to clear them. Clearing the flags re-arms the capture. Errors reported while the memory is still being initialised are discarded.

The log word has a fixed layout. Page number: bits 31:12. Multi-bit flag: bit 1. Single-bit flag: bit 0. Bits 11:2 are always zero. Reads go through a registered read port with one cycle of latency. Writes only affect the two flag bits.

Top module: `ecc_err_logger`

## Requirements
- R1: Synchronous reset (`rst` high at a clock edge) sets the whole log word to 0x00000000 and sets `rd_data` to 0.
- R2: A qualified error while the flags read 00 has three effects at the next clock edge. `err_addr[31:12]` is copied into word bits 31:12. Bit 0 is set if `err_single` is high. Bit 1 is set if `err_multi` is high. A qualified error is one with `err_valid` high, `init_busy` low and at least one flag high.
- R3: While word bits 1:0 are not 00, a further error changes neither the page field nor either flag, unless the same-cycle rule of R7 applies.
- R4: A write (`wr_en` high) with `wr_data[0]` = 1 clears bit 0, and one with `wr_data[1]` = 1 clears bit 1. Writing 0 to a flag leaves it unchanged. Writes never alter bits 31:2, and the page field keeps its value after the flags are cleared.
- R5: Word bits 11:2 always read as 0, whatever was written to them.
- R6: Any error strobe that arrives while `init_busy` is high is ignored.
- R7: Suppose a write in one cycle clears every flag that is set, and a qualified error arrives in that same cycle. Then the error is captured and its flags are set: capture wins over clear. If a flag still remains set after the write, the error is ignored.
- R8: An `err_valid` strobe with both `err_single` and `err_multi` low is ignored.
- R9: When `rd_en` is high at a clock edge, `rd_data` takes the log word as it stood just before that edge. While `rd_en` is low, `rd_data` holds its value.
- R10: An error that has both `err_single` and `err_multi` high sets both flags, so bits 1:0 become 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| err_valid | input | 1 | Error report strobe from the ECC checker |
| err_single | input | 1 | Reported error is single-bit |
| err_multi | input | 1 | Reported error is multi-bit |
| err_addr | input | ADDR_W | Address of the failing access |
| init_busy | input | 1 | Memory initialisation in progress |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | ADDR_W | Write data, ones in bits 1:0 clear flags |
| rd_en | input | 1 | Register read strobe |
| rd_data | output | ADDR_W | Registered read data |

## Verification
The lock is held as state in the two flag bits. If those bits drift from what they should hold, the fault appears at the read port on the very next read. A stuck lock shows up as a page field that stays unchanged after an error on a cleared log. A lost lock shows up as a page field overwritten by a second error, one read after that error. A wrong priority between capture and clear is visible on the read that follows the shared cycle, as either zero flags or a stale page. The vector walk therefore reads the word back after every single stimulus cycle, so each error shows up no more than two cycles after it is caused.

// File: rtl/ecc_log_pkg.sv
package ecc_log_pkg;

  // Positions of the two status flags inside the log word.
  localparam int SBE_POS = 0;
  localparam int MBE_POS = 1;
  localparam int FLAG_W  = 2;

  typedef struct packed {
    logic multi;
    logic single;
  } err_flags_t;

  localparam err_flags_t NO_FLAGS = '{multi: 1'b0, single: 1'b0};

endpackage

// File: rtl/ecc_log_qual.sv
// Qualifies a raw error report: drops reports during initialisation
// and reports that carry no error type.
module ecc_log_qual
  import ecc_log_pkg::*;
(
  input  logic       err_valid,
  input  logic       err_single,
  input  logic       err_multi,
  input  logic       init_busy,
  output logic       hit,
  output err_flags_t hit_flags
);

  always_comb begin
    hit_flags.single = err_single;
    hit_flags.multi  = err_multi;
    hit = err_valid && !init_busy && (err_single || err_multi);
  end

endmodule

// File: rtl/ecc_log_status.sv
// Holds the two status flags; a non-zero value locks the log.
// Clear is applied first, then capture is allowed if nothing is left set.
module ecc_log_status
  import ecc_log_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       hit,
  input  err_flags_t hit_flags,
  input  logic       clr_en,
  input  err_flags_t clr_mask,
  output err_flags_t flags_q,
  output logic       capture
);

  err_flags_t remain;
  err_flags_t flags_d;

  always_comb begin
    remain  = flags_q;
    if (clr_en) begin
      remain = flags_q & ~clr_mask;
    end
    capture = hit && (remain == NO_FLAGS);
    flags_d = capture ? hit_flags : remain;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flags_q <= NO_FLAGS;
    end else begin
      flags_q <= flags_d;
    end
  end

endmodule

// File: rtl/ecc_log_page.sv
// Page number store, loaded only on a capture.
module ecc_log_page #(
  parameter int PAGE_W = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              capture,
  input  logic [PAGE_W-1:0] page_in,
  output logic [PAGE_W-1:0] page_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      page_q <= '0;
    end else if (capture) begin
      page_q <= page_in;
    end
  end

endmodule

// File: rtl/ecc_err_logger.sv
module ecc_err_logger
  import ecc_log_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int PAGE_LSB = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              err_valid,
  input  logic              err_single,
  input  logic              err_multi,
  input  logic [ADDR_W-1:0] err_addr,
  input  logic              init_busy,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [ADDR_W-1:0] rd_data
);

  localparam int PAGE_W = ADDR_W - PAGE_LSB;
  localparam int RSV_W  = PAGE_LSB - FLAG_W;

  logic              hit;
  err_flags_t        hit_flags;
  err_flags_t        clr_mask;
  err_flags_t        flags_q;
  logic              capture;
  logic [PAGE_W-1:0] page_q;
  logic [ADDR_W-1:0] log_word;

  ecc_log_qual qual_i (
    .err_valid (err_valid),
    .err_single(err_single),
    .err_multi (err_multi),
    .init_busy (init_busy),
    .hit       (hit),
    .hit_flags (hit_flags)
  );

  always_comb begin
    clr_mask.single = wr_data[SBE_POS];
    clr_mask.multi  = wr_data[MBE_POS];
  end

  ecc_log_status status_i (
    .clk      (clk),
    .rst      (rst),
    .hit      (hit),
    .hit_flags(hit_flags),
    .clr_en   (wr_en),
    .clr_mask (clr_mask),
    .flags_q  (flags_q),
    .capture  (capture)
  );

  ecc_log_page #(.PAGE_W(PAGE_W)) page_i (
    .clk    (clk),
    .rst    (rst),
    .capture(capture),
    .page_in(err_addr[ADDR_W-1:PAGE_LSB]),
    .page_q (page_q)
  );

  always_comb begin
    log_word = {page_q, {RSV_W{1'b0}}, flags_q.multi, flags_q.single};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else if (rd_en) begin
      rd_data <= log_word;
    end
  end

endmodule

// File: rtl/ecc_err_logger_chk.sv
module ecc_err_logger_chk #(
  parameter int ADDR_W   = 32,
  parameter int PAGE_LSB = 12
) (
  input logic              clk,
  input logic              rst,
  input logic              err_valid,
  input logic              err_single,
  input logic              err_multi,
  input logic [ADDR_W-1:0] err_addr,
  input logic              init_busy,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_data,
  input logic              rd_en,
  input logic [ADDR_W-1:0] rd_data,
  input logic [ADDR_W-1:0] log_word
);

  // R3: the page field is frozen while some flag survives this cycle's write
  p_lock_r3: assert property (@(posedge clk) disable iff (rst)
    ((log_word[1:0] != 2'b00) &&
     !(wr_en && ((log_word[1:0] & ~wr_data[1:0]) == 2'b00)))
    |=> $stable(log_word[ADDR_W-1:PAGE_LSB]));

  // R2: a qualified single-bit error on a clear log loads page and flag
  p_capture_r2: assert property (@(posedge clk) disable iff (rst)
    (err_valid && err_single && !init_busy && (log_word[1:0] == 2'b00))
    |=> (log_word[0] &&
         (log_word[ADDR_W-1:PAGE_LSB] == $past(err_addr[ADDR_W-1:PAGE_LSB]))));

  // R6: nothing changes when the only activity is an error during init
  p_init_ignore_r6: assert property (@(posedge clk) disable iff (rst)
    (init_busy && !wr_en) |=> $stable(log_word));

  // R4: writing 1 to the single-bit flag clears it if no error competes
  p_w1c_r4: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_data[0] && !err_valid) |=> !log_word[0]);

  // R9: read data follows the pre-edge word
  p_read_r9: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> (rd_data == $past(log_word)));

  // R9: read data holds when no read is requested
  p_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rd_data));

endmodule

bind ecc_err_logger ecc_err_logger_chk #(
  .ADDR_W  (ADDR_W),
  .PAGE_LSB(PAGE_LSB)
) chk_i (
  .clk       (clk),
  .rst       (rst),
  .err_valid (err_valid),
  .err_single(err_single),
  .err_multi (err_multi),
  .err_addr  (err_addr),
  .init_busy (init_busy),
  .wr_en     (wr_en),
  .wr_data   (wr_data),
  .rd_en     (rd_en),
  .rd_data   (rd_data),
  .log_word  (log_word)
);

// File: tb/ecc_err_logger_tb.sv
module ecc_err_logger_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 32;
  localparam int WATCHDOG   = 5000;

  typedef struct packed {
    logic        v;
    logic        s;
    logic        m;
    logic        i;
    logic [31:0] a;
    logic        we;
    logic [31:0] wd;
    logic [31:0] exp;
    int          req;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{1'b1,1'b1,1'b0,1'b0,32'h1234_5ABC,1'b0,32'h0,        32'h1234_5001, 2},  // R2 single capture
    '{1'b1,1'b0,1'b1,1'b0,32'hAAAA_A000,1'b0,32'h0,        32'h1234_5001, 3},  // R3 locked
    '{1'b0,1'b0,1'b0,1'b0,32'h0,        1'b1,32'h0000_0002,32'h1234_5001, 4},  // R4 clear unset flag
    '{1'b0,1'b0,1'b0,1'b0,32'h0,        1'b1,32'h0,        32'h1234_5001, 4},  // R4 write 0
    '{1'b0,1'b0,1'b0,1'b0,32'h0,        1'b1,32'h0000_0001,32'h1234_5000, 4},  // R4 clear keeps page
    '{1'b1,1'b0,1'b1,1'b1,32'hFFFF_F000,1'b0,32'h0,        32'h1234_5000, 6},  // R6 during init
    '{1'b1,1'b0,1'b1,1'b0,32'h8000_0FFF,1'b0,32'h0,        32'h8000_0002, 2},  // R2 multi capture
    '{1'b1,1'b1,1'b0,1'b0,32'h0BAD_C000,1'b1,32'h0000_0002,32'h0BAD_C001, 7},  // R7 capture wins
    '{1'b1,1'b0,1'b0,1'b0,32'h5555_5000,1'b1,32'h0000_0001,32'h0BAD_C000, 8},  // R8 no-flag strobe
    '{1'b0,1'b0,1'b0,1'b0,32'h0,        1'b1,32'hFFFF_FFFF,32'h0BAD_C000, 5},  // R5 reserved stay 0
    '{1'b1,1'b1,1'b1,1'b0,32'hFFFF_FFFF,1'b0,32'h0,        32'hFFFF_F003,10},  // R10 both flags
    '{1'b1,1'b1,1'b0,1'b0,32'h0000_1000,1'b1,32'h0000_0001,32'hFFFF_F002, 7},  // R7 flag remains
    '{1'b1,1'b1,1'b0,1'b0,32'h0000_1000,1'b1,32'h0000_0002,32'h0000_1001, 7}   // R7 full clear
  };

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              err_valid = 1'b0;
  logic              err_single = 1'b0;
  logic              err_multi = 1'b0;
  logic [ADDR_W-1:0] err_addr = '0;
  logic              init_busy = 1'b0;
  logic              wr_en = 1'b0;
  logic [ADDR_W-1:0] wr_data = '0;
  logic              rd_en = 1'b0;
  logic [ADDR_W-1:0] rd_data;

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ecc_err_logger #(.ADDR_W(ADDR_W), .PAGE_LSB(12)) dut_i (
    .clk       (clk),
    .rst       (rst),
    .err_valid (err_valid),
    .err_single(err_single),
    .err_multi (err_multi),
    .err_addr  (err_addr),
    .init_busy (init_busy),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .rd_en     (rd_en),
    .rd_data   (rd_data)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic drive(input vec_t t);
    @(negedge clk);
    err_valid = t.v; err_single = t.s; err_multi = t.m; init_busy = t.i;
    err_addr = t.a; wr_en = t.we; wr_data = t.wd;
    @(negedge clk);
    err_valid = 0; err_single = 0; err_multi = 0; init_busy = 0;
    err_addr = '0; wr_en = 0; wr_data = '0;
  endtask

  task automatic read_word(output logic [31:0] val);
    @(negedge clk);
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    val = rd_data;
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  endtask

  initial begin
    for (int c = 0; c < WATCHDOG; c++) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual=timeout expected=done");
      summary();
    end
  end

  initial begin
    logic [31:0] w;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R1 rd_data after reset", rd_data, 32'h0);
    read_word(w);
    check("R1 word after reset", w, 32'h0);

    for (int k = 0; k < NV; k++) begin
      drive(VECS[k]);
      read_word(w);
      check($sformatf("R%0d vector %0d", VECS[k].req, k), w, VECS[k].exp);
    end

    // R9: rd_data holds while rd_en is low, across a state change
    drive('{1'b0,1'b0,1'b0,1'b0,32'h0,1'b1,32'h0000_0001,32'h0,9});
    check("R9 hold while idle", rd_data, 32'h0000_1001);
    read_word(w);
    check("R9 read after clear", w, 32'h0000_1000);

    // R9: a read in the same cycle as a capture returns the pre-edge word
    @(negedge clk);
    rd_en = 1'b1; err_valid = 1'b1; err_multi = 1'b1; err_addr = 32'hCAFE_0123;
    @(negedge clk);
    rd_en = 1'b0; err_valid = 1'b0; err_multi = 1'b0; err_addr = '0;
    check("R9 same-cycle read", rd_data, 32'h0000_1000);
    read_word(w);
    check("R2 capture beside read", w, 32'hCAFE_0002);

    // R6: init high ignores even a clean-log error
    drive('{1'b0,1'b0,1'b0,1'b0,32'h0,1'b1,32'h0000_0002,32'h0,6});
    drive('{1'b1,1'b1,1'b1,1'b1,32'h7777_7000,1'b0,32'h0,32'h0,6});
    read_word(w);
    check("R6 init on clean log", w, 32'hCAFE_0000);

    // R1: reset mid-run clears the word and read data
    drive('{1'b1,1'b1,1'b0,1'b0,32'h4444_4000,1'b0,32'h0,32'h0,1});
    @(negedge clk); rst = 1'b1;
    @(negedge clk); @(negedge clk); rst = 1'b0;
    check("R1 rd_data after mid reset", rd_data, 32'h0);
    read_word(w);
    check("R1 word after mid reset", w, 32'h0);

    finished = 1'b1;
    summary();
  end

endmodule